// File: doc/BRIEF.md
# Boot-Card Bus Slave Decoder

This block is the slave side of a boot card on a 16-bit processor bus. The bus is word-addressed and uses separate strobes for address valid (sync), read (data-in), write (data-out) and reply. When sync rises, the block captures the address and decodes it into one of four windows: a 3K-word read-only boot store, a 256-word scratch RAM, a byte register that holds a network identifier, and a word register that holds a unit identifier. The two identifiers come from switch inputs.

Once the master raises a strobe for a window that accepts the access, a programmable number of clocks passes and then the block raises reply. For a read, it presents the addressed data while reply is high. A write to the read-only store or to the unit-identifier word gets no reply at all, so the master's bus timeout marks the access as illegal. A write to the network-identifier address raises a one-cycle strobe toward an external watchdog.

The boot store is computed, not held in an array. Each 1K-word section is a separate select, and the section pattern is a fixed function of the word index. The scratch RAM is a behavioural array that accepts both word and byte writes.

Top module: `bootcard_slave`

## Requirements
- R1: The window and word index are captured on the clock edge where sync_i is first seen high. They are held until sync_i falls, so changes on addr_i later in the same cycle have no effect.
- R2: A read in 0xE000..0xF7FE (octal 160000..173776) returns word i = (addr-0xE000)/2 as (i*40503 mod 65536) XOR 0x1234. The store is split into three 1K-word sections, selected by address bits 12:11 = 0, 1 and 2.
- R3: A write anywhere in the boot-store window gets no reply, and the stored data does not change.
- R4: The scratch RAM at 0xF800..0xF9FE (octal 174000..174776, 256 words) returns on a read the last word written.
- R5: A write with byte_wr_i high changes one byte only. Address bit 0 = 1 writes wdata_i[15:8] into the upper byte; bit 0 = 0 writes wdata_i[7:0] into the lower byte.
- R6: A read at 0xFA00 or 0xFA01 (octal 175000/175001) returns 0xFF in bits 15:8 and net_id_i in bits 7:0.
- R7: A read at 0xFA02 (octal 175002) returns {unit_hi_i, unit_lo_i}. A write there gets no reply.
- R8: A write to 0xFA00 gets a reply. wdog_kick_o is high for exactly the first cycle in which rply_o is high. No other access raises wdog_kick_o.
- R9: rply_o rises on the RPLY_DLY-th rising edge at which a strobe is sampled high, stays high while the strobe is held, and clears on the first edge at which both strobes are low.
- R10: An address outside the four windows, such as 0x1000 or 0xFA04, gets no reply.
- R11: After reset, rply_o, wdog_kick_o and rdata_o are all zero.
- R12: rdata_o is zero except while both rply_o and din_i are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Address valid; frames one bus cycle |
| addr_i | input | 16 | Byte address, captured when sync rises |
| din_i | input | 1 | Read strobe |
| dout_i | input | 1 | Write strobe |
| byte_wr_i | input | 1 | Write only the byte selected by address bit 0 |
| wdata_i | input | 16 | Write data |
| net_id_i | input | 8 | Network identifier switches |
| unit_hi_i | input | 8 | Unit identifier, upper switch bank |
| unit_lo_i | input | 8 | Unit identifier, lower switch bank |
| rdata_o | output | 16 | Read data, valid while reply and read are high |
| rply_o | output | 1 | Reply strobe |
| wdog_kick_o | output | 1 | One-cycle watchdog restart strobe |

## Verification
A wrong latched window or index shows on rdata_o in the reply cycle of that same bus cycle, either as a wrong pattern word or as a reply where none is due. A corrupt reply counter shows as reply arriving earlier or later than RPLY_DLY sampled edges after the strobe. It can also show as reply staying high one edge after the strobe is released. A RAM write that goes to the wrong lane or the wrong location shows on the next read of that word. A stray watchdog strobe shows in the first cycle of the reply.

// File: rtl/bootcard_pkg.sv
package bootcard_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_ROM  = 3'd1,
    RG_RAM  = 3'd2,
    RG_NET  = 3'd3,
    RG_UNIT = 3'd4
  } region_e;

  // window decode of a full byte address
  function automatic region_e decode_win(input logic [15:0] a);
    region_e r;
    r = RG_NONE;
    if (a[15:13] == 3'b111) begin
      if (a[12:11] != 2'b11)            r = RG_ROM;
      else if (a[10:9] == 2'b00)        r = RG_RAM;
      else if (a[10:1] == 10'h100)      r = RG_NET;
      else if (a[10:1] == 10'h101)      r = RG_UNIT;
    end
    return r;
  endfunction

  // boot store contents as a function of word index
  function automatic logic [15:0] rom_word(input logic [15:0] idx);
    logic [15:0] m;
    m = idx * 16'd40503;
    return m ^ 16'h1234;
  endfunction
endpackage

// File: rtl/bus_addr_latch.sv
module bus_addr_latch
  import bootcard_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SEC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [15:0]      addr_i,
  output region_e          region_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             bhi_o
);
  logic sync_q;
  logic start;

  assign start = sync_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      region_o <= RG_NONE;
      sec_o    <= '0;
      idx_o    <= '0;
      bhi_o    <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (!sync_i) begin
        region_o <= RG_NONE;
      end else if (start) begin
        region_o <= decode_win(addr_i);
        sec_o    <= addr_i[12:11];
        idx_o    <= addr_i[IDX_W:1];
        bhi_o    <= addr_i[0];
      end
    end
  end
endmodule

// File: rtl/boot_rom.sv
module boot_rom
  import bootcard_pkg::*;
#(
  parameter int N_SEC  = 3,
  parameter int SEC_AW = 10,
  parameter int SEC_W  = 2
) (
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [SEC_AW-1:0] word_i,
  output logic [15:0]       data_o
);
  localparam int IW = SEC_W + SEC_AW;

  logic [15:0] part [N_SEC];

  for (genvar g = 0; g < N_SEC; g++) begin : g_sec
    logic [IW-1:0] full_idx;
    assign full_idx = {SEC_W'(g), word_i};
    assign part[g] = (sec_i == SEC_W'(g)) ? rom_word(16'(full_idx)) : 16'h0000;
  end

  always_comb begin
    data_o = '0;
    for (int k = 0; k < N_SEC; k++) data_o = data_o | part[k];
  end
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          byte_i,
  input  logic          bhi_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (!byte_i || bhi_i)  mem[addr_i][15:8] <= wdata_i[15:8];
      if (!byte_i || !bhi_i) mem[addr_i][7:0]  <= wdata_i[7:0];
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/reply_timer.sv
module reply_timer #(
  parameter int DLY = 4,
  localparam int CW = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic ok_i,
  output logic rply_o,
  output logic fire_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      rply_o <= 1'b0;
      fire_o <= 1'b0;
    end else if (!strobe_i) begin
      cnt    <= '0;
      rply_o <= 1'b0;
      fire_o <= 1'b0;
    end else if (ok_i && !rply_o) begin
      if (cnt == CW'(DLY - 1)) begin
        rply_o <= 1'b1;
        fire_o <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        fire_o <= 1'b0;
      end
    end else begin
      fire_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bootcard_slave.sv
module bootcard_slave
  import bootcard_pkg::*;
#(
  parameter int RPLY_DLY  = 4,
  parameter int RAM_DEPTH = 256,
  parameter int ROM_SECS  = 3,
  parameter int SEC_AW    = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sync_i,
  input  logic [15:0] addr_i,
  input  logic        din_i,
  input  logic        dout_i,
  input  logic        byte_wr_i,
  input  logic [15:0] wdata_i,
  input  logic [7:0]  net_id_i,
  input  logic [7:0]  unit_hi_i,
  input  logic [7:0]  unit_lo_i,
  output logic [15:0] rdata_o,
  output logic        rply_o,
  output logic        wdog_kick_o
);
  localparam int IDX_W  = SEC_AW + 1;
  localparam int SEC_W  = 2;
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  region_e          region;
  logic [SEC_W-1:0] sec;
  logic [IDX_W-1:0] idx;
  logic             bhi;
  logic [15:0]      rom_d, ram_d;
  logic             ok, fire, ram_we;
  logic [15:0]      mux_d;

  bus_addr_latch #(.IDX_W(IDX_W), .SEC_W(SEC_W)) u_latch (
    .clk_i, .rst_ni, .sync_i, .addr_i,
    .region_o(region), .sec_o(sec), .idx_o(idx), .bhi_o(bhi)
  );

  boot_rom #(.N_SEC(ROM_SECS), .SEC_AW(SEC_AW), .SEC_W(SEC_W)) u_rom (
    .sec_i(sec), .word_i(idx[SEC_AW-1:0]), .data_o(rom_d)
  );

  scratch_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i, .we_i(ram_we), .byte_i(byte_wr_i), .bhi_i(bhi),
    .addr_i(idx[RAM_AW-1:0]), .wdata_i, .rdata_o(ram_d)
  );

  // read-only windows refuse writes: no reply, master times out
  always_comb begin
    unique case (region)
      RG_RAM, RG_NET:  ok = 1'b1;
      RG_ROM, RG_UNIT: ok = ~dout_i;
      default:         ok = 1'b0;
    endcase
  end

  reply_timer #(.DLY(RPLY_DLY)) u_tmr (
    .clk_i, .rst_ni, .strobe_i(din_i | dout_i), .ok_i(ok),
    .rply_o, .fire_o(fire)
  );

  assign ram_we      = fire & dout_i & (region == RG_RAM);
  assign wdog_kick_o = fire & dout_i & (region == RG_NET);

  always_comb begin
    unique case (region)
      RG_ROM:  mux_d = rom_d;
      RG_RAM:  mux_d = ram_d;
      RG_NET:  mux_d = {8'hFF, net_id_i};
      RG_UNIT: mux_d = {unit_hi_i, unit_lo_i};
      default: mux_d = 16'h0000;
    endcase
  end

  assign rdata_o = (rply_o && din_i) ? mux_d : 16'h0000;
endmodule

// File: rtl/bootcard_slave_chk.sv
module bootcard_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sync_i,
  input logic        din_i,
  input logic        dout_i,
  input logic        rply_o,
  input logic        wdog_kick_o
);
  // R9
  rply_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rply_o |-> $past(din_i || dout_i));
  // R9
  rply_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!din_i && !dout_i) |=> !rply_o);
  // R8
  kick_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_kick_o |-> (dout_i && rply_o));
  // R8
  kick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_kick_o |=> !wdog_kick_o);
  // R1
  rply_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rply_o) |-> sync_i);
endmodule

bind bootcard_slave bootcard_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .din_i(din_i),
  .dout_i(dout_i), .rply_o(rply_o), .wdog_kick_o(wdog_kick_o)
);

// File: tb/sim_bootcard_slave.sv
module sim_bootcard_slave;
  localparam int DLY = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0, din_i = 1'b0, dout_i = 1'b0, byte_wr_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [7:0]  net_id_i = 8'h5A, unit_hi_i = 8'hC3, unit_lo_i = 8'h7E;
  logic [15:0] rdata_o;
  logic        rply_o, wdog_kick_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  bootcard_slave #(.RPLY_DLY(DLY)) u0 (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    logic [15:0] m;
    m = 16'(i * 40503);
    return m ^ 16'h1234;
  endfunction

  // one bus cycle; a_late replaces addr_i after sync rises
  task automatic bus(input logic [15:0] a, input logic [15:0] a_late, input logic wr,
                     input logic bw, input logic [15:0] wd, input logic exp_r,
                     input logic [15:0] exp_d, input logic exp_k, input string tag);
    int k;
    logic got;
    @(negedge clk_i); addr_i = a; sync_i = 1'b1;
    @(negedge clk_i); addr_i = a_late;
    byte_wr_i = bw; wdata_i = wd;
    if (wr) dout_i = 1'b1; else din_i = 1'b1;
    got = 1'b0;
    for (k = 1; k <= 4 * DLY + 4; k++) begin
      @(negedge clk_i);
      if (rply_o) begin got = 1'b1; break; end
    end
    chk(got == exp_r, {tag, " reply presence"}, got, exp_r);
    if (got && exp_r) begin
      chk(k == DLY, "R9 reply delay", k, DLY);
      if (!wr) chk(rdata_o == exp_d, {tag, " data"}, rdata_o, exp_d);
      chk(wdog_kick_o == exp_k, "R8 kick at reply", wdog_kick_o, exp_k);
      @(negedge clk_i);
      chk(wdog_kick_o == 1'b0, "R8 kick one cycle", wdog_kick_o, 0);
      chk(rply_o == 1'b1, "R9 reply held", rply_o, 1);
    end
    din_i = 1'b0; dout_i = 1'b0; byte_wr_i = 1'b0;
    @(negedge clk_i);
    chk(rply_o == 1'b0, "R9 reply drops", rply_o, 0);
    chk(rdata_o == 16'h0, "R12 data idle", rdata_o, 0);
    sync_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(rply_o == 0, "R11 rply", rply_o, 0);
    chk(rdata_o == 0, "R11 rdata", rdata_o, 0);
    chk(wdog_kick_o == 0, "R11 kick", wdog_kick_o, 0);
  endtask

  task automatic t_rom();
    bus(16'hE000, 16'hE000, 0, 0, 0, 1, pat(0), 0, "R2 rom first");
    bus(16'hE800, 16'hE800, 0, 0, 0, 1, pat(1024), 0, "R2 rom sec1");
    bus(16'hF7FE, 16'hF7FE, 0, 0, 0, 1, pat(3071), 0, "R2 rom last");
    bus(16'hF000, 16'hF000, 0, 0, 0, 1, pat(2048), 0, "R2 rom sec2");
  endtask

  task automatic t_rom_write();
    bus(16'hE002, 16'hE002, 1, 0, 16'hFFFF, 0, 0, 0, "R3 rom write");
    bus(16'hE002, 16'hE002, 0, 0, 0, 1, pat(1), 0, "R3 rom unchanged");
  endtask

  task automatic t_ram();
    bus(16'hF800, 16'hF800, 1, 0, 16'h1357, 1, 0, 0, "R4 ram wr0");
    bus(16'hF9FE, 16'hF9FE, 1, 0, 16'hBEEF, 1, 0, 0, "R4 ram wr255");
    bus(16'hF800, 16'hF800, 0, 0, 0, 1, 16'h1357, 0, "R4 ram rd0");
    bus(16'hF9FE, 16'hF9FE, 0, 0, 0, 1, 16'hBEEF, 0, "R4 ram rd255");
  endtask

  task automatic t_byte();
    bus(16'hF804, 16'hF804, 1, 0, 16'h1111, 1, 0, 0, "R5 init");
    bus(16'hF805, 16'hF805, 1, 1, 16'hAB99, 1, 0, 0, "R5 hi write");
    bus(16'hF804, 16'hF804, 0, 0, 0, 1, 16'hAB11, 0, "R5 hi lane");
    bus(16'hF804, 16'hF804, 1, 1, 16'h77CD, 1, 0, 0, "R5 lo write");
    bus(16'hF804, 16'hF804, 0, 0, 0, 1, 16'hABCD, 0, "R5 lo lane");
  endtask

  task automatic t_ids();
    bus(16'hFA00, 16'hFA00, 0, 0, 0, 1, 16'hFF5A, 0, "R6 net id");
    bus(16'hFA01, 16'hFA01, 0, 0, 0, 1, 16'hFF5A, 0, "R6 net odd");
    bus(16'hFA02, 16'hFA02, 0, 0, 0, 1, 16'hC37E, 0, "R7 unit id");
    bus(16'hFA02, 16'hFA02, 1, 0, 16'h0000, 0, 0, 0, "R7 unit write");
  endtask

  task automatic t_kick();
    bus(16'hFA00, 16'hFA00, 1, 0, 16'h0000, 1, 0, 1, "R8 kick write");
    bus(16'hF806, 16'hF806, 1, 0, 16'h2222, 1, 0, 0, "R8 ram no kick");
  endtask

  task automatic t_unmapped();
    bus(16'h1000, 16'h1000, 0, 0, 0, 0, 0, 0, "R10 low addr");
    bus(16'hFA04, 16'hFA04, 0, 0, 0, 0, 0, 0, "R10 past ids");
  endtask

  task automatic t_latch();
    bus(16'hF800, 16'h1000, 0, 0, 0, 1, 16'h1357, 0, "R1 late addr");
    bus(16'h1000, 16'hE000, 0, 0, 0, 0, 0, 0, "R1 late into rom");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_rom();
    t_rom_write();
    t_ram();
    t_byte();
    t_ids();
    t_kick();
    t_unmapped();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule